// File: doc/BRIEF.md
# NAND Flash Bus Glue Decoder

This block joins a host memory window to two byte-wide NAND flash slots and to a small register window. Each host request carries an address, a direction and a data word. The block sorts the request by a few address bits. A flash access drives one slot's active-low chip enable together with the command and address latch enables, which are taken directly from host address bits, and pulses the matching write or read strobe for one cycle. A register access touches no flash pin. It can read a status word that shows the synchronized ready/busy line of the slot addressed most recently. An address with no window bit set is dropped.

The host side uses a valid/ready request and a one-cycle response pulse. Every accepted request, whatever its kind, gets exactly one response two clock edges after it is accepted. The block takes no new request until that response has been given.

Top module: `nand_glue_decoder`

## Requirements
- R1: After reset, both chip enables are high, both strobes are high, CLE, ALE and the data output enable are low, resp_valid is low and req_ready is high.
- R2: With address bit 24 clear, bits 23..22 = 2'b10 select slot index 0 (fl_ce_n = 2'b10) and 2'b11 select slot index 1 (fl_ce_n = 2'b01). The enable is low only during the cycle after acceptance, and at most one enable is ever low.
- R3: During a flash strobe, fl_cle equals host address bit 5 and fl_ale equals host address bit 4. When both are 0 the access is a plain data transfer.
- R4: A flash write drives fl_we_n low for exactly one cycle, with fl_dq_out = req_wdata[7:0] and fl_dq_oe high. fl_re_n stays high and the upper write-data bits are ignored.
- R5: A flash read drives fl_re_n low for exactly one cycle. The response data is {8'h00, fl_dq_in}, with fl_dq_in sampled at the clock edge that ends the strobe.
- R6: Address bit 24 set selects the register window, whatever bits 23..22 hold. The access then drives no chip enable and no strobe.
- R7: A register read at window offset 0x2 (address bits 3..0) returns bit 0 = synchronized ready/busy (1 ready, 0 busy) of the slot used by the most recent flash access (slot index 0 after reset), with bits 15..1 zero. Other offsets read 0. Register writes change nothing and respond with data 0.
- R8: fl_rb passes through a two-flop synchronizer. A status read accepted at the second clock edge after fl_rb changes still returns the old level. A read accepted later returns the new level.
- R9: An access with address bits 24..23 both 0 is ignored. It drives no enable or strobe, leaves the remembered slot unchanged and responds with data 0.
- R10: req_ready is low from acceptance until the response. resp_valid is high for one cycle, in the cycle after the second clock edge following acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | Host byte address |
| req_wdata | input | 16 | Host write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 16 | Response read data |
| fl_ce_n | output | 2 | Active-low chip enable per slot |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_re_n | output | 1 | Active-low read strobe |
| fl_dq_out | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_in | input | 8 | Flash data in |
| fl_rb | input | 2 | Ready/busy per slot, 1 = ready |

## Verification
The host drives a request at a falling edge, and the request is accepted at the next rising edge. The flash strobe then appears in the cycle right after that edge, and the response appears one cycle later. The bench samples the flash pins and req_ready at the falling edge inside the strobe cycle, and the response at the falling edge that follows. A monitor keeps a snapshot of any strobe activity and compares it against the queued expectation when the response arrives. The synchronizer check changes fl_rb one cycle before it presents the request, so the read is accepted at exactly the second edge after the change.

// File: rtl/nand_glue_pkg.sv
package nand_glue_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_FLASH = 2'd1,
      ACC_REG   = 2'd2
   } acc_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_RESP = 2'd2
   } seq_state_t;
endpackage

// File: rtl/nglue_decode.sv
module nglue_decode
   import nand_glue_pkg::*;
#(
   parameter int ADDR_W     = 25,
   parameter int WIN_BIT    = 24,
   parameter int SLOT_LSB   = 22,
   parameter int CLE_BIT    = 5,
   parameter int ALE_BIT    = 4,
   parameter int REG_OFF_W  = 4,
   parameter int STATUS_OFF = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_t         kind,
   output logic              slot_idx,
   output logic              cle,
   output logic              ale,
   output logic              status_hit
);
   localparam int SLOT_MSB = SLOT_LSB + 1;

   initial begin
      assert (WIN_BIT < ADDR_W && SLOT_MSB < WIN_BIT)
         else $error("nglue_decode: select bits out of range");
      assert (CLE_BIT < SLOT_LSB && ALE_BIT < SLOT_LSB && CLE_BIT != ALE_BIT)
         else $error("nglue_decode: latch bits collide");
      assert (STATUS_OFF < (1 << REG_OFF_W))
         else $error("nglue_decode: status offset too wide");
   end

   logic unused_addr;
   assign unused_addr = ^addr;

   always_comb begin
      if (addr[WIN_BIT])
         kind = ACC_REG;
      else if (addr[SLOT_MSB])
         kind = ACC_FLASH;
      else
         kind = ACC_NONE;
   end

   assign slot_idx   = addr[SLOT_LSB];
   assign cle        = addr[CLE_BIT];
   assign ale        = addr[ALE_BIT];
   assign status_hit = (addr[REG_OFF_W-1:0] == REG_OFF_W'(STATUS_OFF));
endmodule

// File: rtl/nglue_sync.sv
module nglue_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   initial begin
      assert (STAGES >= 2) else $error("nglue_sync: need at least two stages");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/nglue_seq.sv
module nglue_seq
   import nand_glue_pkg::*;
#(
   parameter int HOST_W    = 16,
   parameter int DQ_W      = 8,
   parameter int NUM_SLOTS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [DQ_W-1:0]   wbyte,
   input  acc_kind_t         dec_kind,
   input  logic              dec_slot,
   input  logic              dec_cle,
   input  logic              dec_ale,
   input  logic [HOST_W-1:0] reg_rdata,
   output logic              sel_slot,
   output logic              resp_valid,
   output logic [HOST_W-1:0] resp_rdata,
   output logic [NUM_SLOTS-1:0] fl_ce_n,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_we_n,
   output logic              fl_re_n,
   output logic [DQ_W-1:0]   fl_dq_out,
   output logic              fl_dq_oe,
   input  logic [DQ_W-1:0]   fl_dq_in
);
   localparam int PAD_W = HOST_W - DQ_W;

   initial begin
      assert (NUM_SLOTS == 2) else $error("nglue_seq: exactly two slots supported");
      assert (HOST_W > DQ_W) else $error("nglue_seq: host word must exceed flash byte");
   end

   seq_state_t        state_q;
   acc_kind_t         kind_q;
   logic              write_q, slot_q, cle_q, ale_q;
   logic [DQ_W-1:0]   wbyte_q;
   logic [HOST_W-1:0] rdata_q;
   logic              accept, act_fl;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kind_q   <= ACC_NONE;
         write_q  <= 1'b0;
         slot_q   <= 1'b0;
         cle_q    <= 1'b0;
         ale_q    <= 1'b0;
         wbyte_q  <= '0;
         rdata_q  <= '0;
         sel_slot <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_ACT;
               kind_q  <= dec_kind;
               write_q <= req_write;
               slot_q  <= dec_slot;
               cle_q   <= dec_cle;
               ale_q   <= dec_ale;
               wbyte_q <= wbyte;
               rdata_q <= (dec_kind == ACC_REG && !req_write) ? reg_rdata : '0;
               if (dec_kind == ACC_FLASH) sel_slot <= dec_slot;
            end
            ST_ACT: begin
               state_q <= ST_RESP;
               if (kind_q == ACC_FLASH && !write_q)
                  rdata_q <= {{PAD_W{1'b0}}, fl_dq_in};
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign act_fl = (state_q == ST_ACT) && (kind_q == ACC_FLASH);

   genvar g;
   generate
      for (g = 0; g < NUM_SLOTS; g++) begin : g_ce
         assign fl_ce_n[g] = ~(act_fl && (slot_q == g[0]));
      end
   endgenerate

   assign fl_cle     = act_fl && cle_q;
   assign fl_ale     = act_fl && ale_q;
   assign fl_we_n    = ~(act_fl && write_q);
   assign fl_re_n    = ~(act_fl && !write_q);
   assign fl_dq_oe   = act_fl && write_q;
   assign fl_dq_out  = fl_dq_oe ? wbyte_q : '0;
   assign resp_valid = (state_q == ST_RESP);
   assign resp_rdata = resp_valid ? rdata_q : '0;

   a_r10_resp_due: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ##1 resp_valid);
   a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |=> fl_we_n);
   a_r5_re_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_re_n |=> fl_re_n);
   a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_re_n));
endmodule

// File: rtl/nand_glue_decoder.sv
module nand_glue_decoder
   import nand_glue_pkg::*;
#(
   parameter int ADDR_W      = 25,
   parameter int HOST_W      = 16,
   parameter int DQ_W        = 8,
   parameter int NUM_SLOTS   = 2,
   parameter int WIN_BIT     = 24,
   parameter int SLOT_LSB    = 22,
   parameter int CLE_BIT     = 5,
   parameter int ALE_BIT     = 4,
   parameter int REG_OFF_W   = 4,
   parameter int STATUS_OFF  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [HOST_W-1:0]    req_wdata,
   output logic                 resp_valid,
   output logic [HOST_W-1:0]    resp_rdata,
   output logic [NUM_SLOTS-1:0] fl_ce_n,
   output logic                 fl_cle,
   output logic                 fl_ale,
   output logic                 fl_we_n,
   output logic                 fl_re_n,
   output logic [DQ_W-1:0]      fl_dq_out,
   output logic                 fl_dq_oe,
   input  logic [DQ_W-1:0]      fl_dq_in,
   input  logic [NUM_SLOTS-1:0] fl_rb
);
   localparam int SLOT_MSB = SLOT_LSB + 1;

   acc_kind_t             dec_kind;
   logic                  dec_slot, dec_cle, dec_ale, status_hit;
   logic                  sel_slot;
   logic [NUM_SLOTS-1:0]  rb_sync;
   logic [HOST_W-1:0]     reg_rdata;
   logic                  unused_wdata;

   assign unused_wdata = ^req_wdata[HOST_W-1:DQ_W];

   nglue_decode #(
      .ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT), .SLOT_LSB(SLOT_LSB),
      .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT),
      .REG_OFF_W(REG_OFF_W), .STATUS_OFF(STATUS_OFF)
   ) u_decode (
      .addr(req_addr), .kind(dec_kind), .slot_idx(dec_slot),
      .cle(dec_cle), .ale(dec_ale), .status_hit(status_hit)
   );

   nglue_sync #(.WIDTH(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(fl_rb), .q_sync(rb_sync)
   );

   assign reg_rdata = status_hit ? {{(HOST_W-1){1'b0}}, rb_sync[sel_slot]} : '0;

   nglue_seq #(.HOST_W(HOST_W), .DQ_W(DQ_W), .NUM_SLOTS(NUM_SLOTS)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .wbyte(req_wdata[DQ_W-1:0]),
      .dec_kind(dec_kind), .dec_slot(dec_slot), .dec_cle(dec_cle), .dec_ale(dec_ale),
      .reg_rdata(reg_rdata), .sel_slot(sel_slot),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
      .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
      .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
   );

   a_r2_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~fl_ce_n));
   a_r6_window_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_addr[WIN_BIT]) |=> (&fl_ce_n && fl_we_n && fl_re_n));
   a_r9_ignored_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_addr[WIN_BIT] && !req_addr[SLOT_MSB])
      |=> (&fl_ce_n && fl_we_n && fl_re_n && !fl_dq_oe));
   a_r3_latch_only_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_cle || fl_ale) |-> !(&fl_ce_n));
endmodule

// File: tb/nand_glue_decoder_test.sv
`timescale 1ns/1ps
module nand_glue_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [24:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [7:0]  fl_dq_in = '0;
   logic [1:0]  fl_rb = 2'b01;
   logic        req_ready, resp_valid;
   logic [15:0] resp_rdata;
   logic [1:0]  fl_ce_n;
   logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
   logic [7:0]  fl_dq_out;

   always #5 clk = ~clk;

   nand_glue_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
      .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_dq_out(fl_dq_out),
      .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_rb(fl_rb)
   );

   typedef struct packed {
      logic [15:0] rdata;
      logic [1:0]  ce_n;
      logic        cle, ale, we_n, re_n;
      logic [7:0]  dq;
      logic [7:0]  req;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0, n_bad = 0;
   bit   done = 0;

   task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic exp_t mk(input logic [15:0] rd, input logic [1:0] ce,
                               input logic c, input logic a, input logic w,
                               input logic r, input logic [7:0] d, input logic [7:0] rq);
      exp_t e;
      e.rdata = rd; e.ce_n = ce; e.cle = c; e.ale = a;
      e.we_n = w; e.re_n = r; e.dq = d; e.req = rq;
      return e;
   endfunction

   function automatic exp_t quiet(input logic [15:0] rd, input logic [7:0] rq);
      return mk(rd, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, rq);
   endfunction

   // Driver: push expectation, present request, check handshake timing (R10)
   task automatic xact(input logic wr, input logic [24:0] a, input logic [15:0] wd,
                       input logic [7:0] dqi, input exp_t e);
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; fl_dq_in = dqi;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, 10, {31'b0, req_ready}, 32'h0);   // R10 busy in strobe cycle
      @(negedge clk);
      chk(resp_valid == 1'b1, 10, {31'b0, resp_valid}, 32'h1); // R10 response due
   endtask

   // Monitor: snapshot strobes, compare on response
   initial begin
      exp_t snap, e;
      snap = quiet(16'h0, 8'h0);
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (fl_ce_n != 2'b11 || !fl_we_n || !fl_re_n)
               snap = mk(16'h0, fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_out, 8'h0);
            if (resp_valid) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, 10, 32'h1, 32'h0);
               end else begin
                  e = exp_q.pop_front();
                  chk(resp_rdata == e.rdata, int'(e.req), {16'h0, resp_rdata}, {16'h0, e.rdata});
                  chk({snap.ce_n, snap.cle, snap.ale, snap.we_n, snap.re_n, snap.dq} ==
                      {e.ce_n, e.cle, e.ale, e.we_n, e.re_n, e.dq}, int'(e.req),
                      {18'h0, snap.ce_n, snap.cle, snap.ale, snap.we_n, snap.re_n, snap.dq},
                      {18'h0, e.ce_n, e.cle, e.ale, e.we_n, e.re_n, e.dq});
               end
               snap = quiet(16'h0, 8'h0);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         chk(1'b0, 10, 32'h0, 32'h1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(fl_ce_n == 2'b11 && fl_we_n && fl_re_n && !fl_cle && !fl_ale && !fl_dq_oe,
          1, {26'h0, fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale}, 32'h3C);
      chk(!resp_valid && req_ready, 1, {30'h0, resp_valid, req_ready}, 32'h1);
      repeat (4) @(negedge clk);

      // R2 R3 R4: command byte to slot index 0
      xact(1'b1, 25'h080_0020, 16'h0070, 8'h00, mk(16'h0, 2'b10, 1, 0, 0, 1, 8'h70, 2));
      // R4 R2: address byte to slot index 1, upper data ignored
      xact(1'b1, 25'h0C0_0010, 16'hAB3C, 8'h00, mk(16'h0, 2'b01, 0, 1, 0, 1, 8'h3C, 4));
      // R5: data read from slot index 1
      xact(1'b0, 25'h0C0_0000, 16'h0, 8'h5A, mk(16'h005A, 2'b01, 0, 0, 1, 0, 8'h00, 5));
      // R3: plain data write to slot index 0
      xact(1'b1, 25'h080_0000, 16'h0011, 8'h00, mk(16'h0, 2'b10, 0, 0, 0, 1, 8'h11, 3));
      // R6 R7: window wins over slot bits, slot 0 ready
      xact(1'b0, 25'h1C0_0002, 16'h0, 8'hFF, quiet(16'h0001, 6));
      // R7: other offset reads zero
      xact(1'b0, 25'h100_0006, 16'h0, 8'hFF, quiet(16'h0000, 7));
      // R7: register write has no effect
      xact(1'b1, 25'h100_0002, 16'hFFFF, 8'h00, quiet(16'h0000, 7));
      // R9: ignored read and ignored write
      xact(1'b0, 25'h000_0030, 16'h0, 8'hA5, quiet(16'h0000, 9));
      xact(1'b1, 25'h040_0020, 16'h00EE, 8'h00, quiet(16'h0000, 9));
      // R9 R7: remembered slot still index 0
      xact(1'b0, 25'h100_0002, 16'h0, 8'h00, quiet(16'h0001, 9));
      // R3 R5: both latch bits, read from slot index 1
      xact(1'b0, 25'h0C0_0030, 16'h0, 8'hC3, mk(16'h00C3, 2'b01, 1, 1, 1, 0, 8'h00, 3));
      // R7: slot index 1 busy
      xact(1'b0, 25'h100_0002, 16'h0, 8'h00, quiet(16'h0000, 7));
      // R8: change ready line, read accepted at second edge sees old level
      @(negedge clk);
      fl_rb = 2'b11;
      xact(1'b0, 25'h100_0002, 16'h0, 8'h00, quiet(16'h0000, 8));
      // R8: later read sees new level
      xact(1'b0, 25'h100_0002, 16'h0, 8'h00, quiet(16'h0001, 8));

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, 10, exp_q.size(), 32'h0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule